// File: doc/BRIEF.md
# Multi-Channel Descriptor DMA Engine

This block moves data between memory locations on behalf of sixteen independent channels. Each channel owns a descriptor held in an internal register file. The descriptor holds a source address, a destination address, a queue length in items, and a control word. One shared engine serves one channel at a time. It reads an item from the source, then writes it to the destination, through a single-beat memory master port with a request/acknowledge handshake.

A channel becomes pending in one of three ways: its hardware request line pulses, its software start bit pulses, or another channel that links to it completes. The engine takes the lowest-numbered pending channel and runs it to the end of its unit of work, either one item or a whole block. It then writes the advanced addresses back, so a later start resumes the queue. Completion sets a per-channel done flag and can pulse a per-channel interrupt. A software abort stops the engine after the memory beat in flight and flags the channel with an error.

Top module: `dma_engine`

## Requirements
- R1: After reset, mem_req, busy, irq, ch_done and ch_err are all zero.
- R2: In block mode (control bit 4 clear), one start moves all len items of the channel in turn. Each item is a read of the source followed by a write of the destination, and the write data equals the data just read.
- R3: Control bits [1:0] set the item size (0 = 8 bits, 1 = 16 bits, 2 = 32 bits) and appear on mem_size for every beat. The address step is 1, 2 or 4 bytes to match.
- R4: Control bit 2 makes the source address post-increment, and control bit 3 does the same for the destination. With the bit clear, that address stays constant for every item.
- R5: In single mode (control bit 4 set), each start moves exactly one item and completes. The next start continues from the following address.
- R6: When the last item of the queue has moved, a channel with control bit 5 set goes back to its programmed start addresses. Without bit 5, the next start continues past the end.
- R7: A one-cycle pulse on hw_req[c] or on sw_start[c] starts channel c.
- R8: When several channels are pending, the lowest-numbered one is served first. A started block is never preempted.
- R9: On normal completion, ch_done[c] is set. If control bit 6 is set, irq[c] pulses high for exactly one cycle in the same cycle that ch_done[c] is set.
- R10: If control bit 7 is set, normal completion of a channel makes the channel numbered by control bits [11:8] pending on the next cycle, and that channel then runs.
- R11: After a sw_abort pulse, the memory beat in flight finishes and no further beat is issued. The active channel gets ch_done and ch_err set, raises no interrupt and triggers no link, and every pending request is discarded.
- R12: Writing a descriptor through cfg_we clears that channel's ch_done and ch_err flags.
- R13: mem_req holds with mem_addr and mem_we stable until mem_ack. A write beat is issued only after the read beat of the same item has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_ch | input | 4 | Channel whose descriptor is written |
| cfg_src | input | 32 | Start source address |
| cfg_dst | input | 32 | Start destination address |
| cfg_len | input | 16 | Queue length in items |
| cfg_ctrl | input | 12 | Control word (size, increments, mode, circular, interrupt, link) |
| hw_req | input | 16 | Per-channel hardware request pulses |
| sw_start | input | 16 | Per-channel software start pulses |
| sw_abort | input | 1 | Software abort pulse |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Beat byte address |
| mem_size | output | 2 | Beat item size code |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Beat acknowledge |
| irq | output | 16 | Per-channel completion interrupt pulses |
| ch_done | output | 16 | Per-channel done flags |
| ch_err | output | 16 | Per-channel abort error flags |
| busy | output | 1 | Engine is serving a channel |

## Verification
The bench aims at the queue-end boundary. A design that restored addresses without the circular bit, or forgot to restore them with it, would start the second run from the wrong address. Simultaneous starts on two channels expose an arbiter that favours the higher number or preempts a running block, because the beat log then interleaves or begins at the wrong source. An abort placed between the read and the write of the first item catches an engine that drops the write in flight, keeps issuing beats, raises the interrupt anyway, or later serves a channel that was pending at the abort. Linked channels check that the target runs only after the source completes, and single mode checks that each start moves exactly one item.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_FIN  = 2'd3
  } dma_state_e;

  // control word field positions
  localparam int C_SIZE_LO = 0;
  localparam int C_SRC_INC = 2;
  localparam int C_DST_INC = 3;
  localparam int C_SINGLE  = 4;
  localparam int C_CIRC    = 5;
  localparam int C_INT     = 6;
  localparam int C_LINK    = 7;
  localparam int C_LCH_LO  = 8;

  function automatic logic [2:0] step_of(input logic [1:0] sz);
    case (sz)
      2'd0:    step_of = 3'd1;
      2'd1:    step_of = 3'd2;
      default: step_of = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_desc_file.sv
module dma_desc_file #(
  parameter int NCH = 16,
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int CTW = 12,
  parameter int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [AW-1:0]  cfg_src,
  input  logic [AW-1:0]  cfg_dst,
  input  logic [CW-1:0]  cfg_len,
  input  logic [CTW-1:0] cfg_ctrl,
  input  logic [CHW-1:0] rd_ch,
  output logic [AW-1:0]  rd_cur_src,
  output logic [AW-1:0]  rd_cur_dst,
  output logic [AW-1:0]  rd_base_src,
  output logic [AW-1:0]  rd_base_dst,
  output logic [CW-1:0]  rd_rem,
  output logic [CW-1:0]  rd_len,
  output logic [CTW-1:0] rd_ctrl,
  input  logic           wb_en,
  input  logic [CHW-1:0] wb_ch,
  input  logic [AW-1:0]  wb_src,
  input  logic [AW-1:0]  wb_dst,
  input  logic [CW-1:0]  wb_rem,
  input  logic           clr_en,
  input  logic [CHW-1:0] clr_ch,
  input  logic           fin_en,
  input  logic           fin_err,
  input  logic [CHW-1:0] fin_ch,
  output logic [NCH-1:0] done_o,
  output logic [NCH-1:0] err_o
);

  logic [AW-1:0]  base_src_q [NCH];
  logic [AW-1:0]  base_dst_q [NCH];
  logic [AW-1:0]  cur_src_q  [NCH];
  logic [AW-1:0]  cur_dst_q  [NCH];
  logic [CW-1:0]  len_q      [NCH];
  logic [CW-1:0]  rem_q      [NCH];
  logic [CTW-1:0] ctrl_q     [NCH];
  logic [NCH-1:0] cfg_hit, wb_hit;
  logic [NCH-1:0] done_q, done_d, err_q, err_d;

  // per-channel write decode
  for (genvar g = 0; g < NCH; g++) begin : g_dec
    assign cfg_hit[g] = cfg_we && (cfg_ch == CHW'(g));
    assign wb_hit[g]  = wb_en  && (wb_ch  == CHW'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (cfg_hit[i]) begin
        base_src_q[i] <= cfg_src;
        base_dst_q[i] <= cfg_dst;
        cur_src_q[i]  <= cfg_src;
        cur_dst_q[i]  <= cfg_dst;
        len_q[i]      <= cfg_len;
        rem_q[i]      <= cfg_len;
        ctrl_q[i]     <= cfg_ctrl;
      end else if (wb_hit[i]) begin
        cur_src_q[i]  <= wb_src;
        cur_dst_q[i]  <= wb_dst;
        rem_q[i]      <= wb_rem;
      end
    end
  end

  assign rd_cur_src  = cur_src_q[rd_ch];
  assign rd_cur_dst  = cur_dst_q[rd_ch];
  assign rd_base_src = base_src_q[rd_ch];
  assign rd_base_dst = base_dst_q[rd_ch];
  assign rd_rem      = rem_q[rd_ch];
  assign rd_len      = len_q[rd_ch];
  assign rd_ctrl     = ctrl_q[rd_ch];

  always_comb begin
    done_d = done_q;
    err_d  = err_q;
    if (clr_en) begin
      done_d[clr_ch] = 1'b0;
      err_d[clr_ch]  = 1'b0;
    end
    if (cfg_we) begin
      done_d[cfg_ch] = 1'b0;
      err_d[cfg_ch]  = 1'b0;
    end
    if (fin_en) begin
      done_d[fin_ch] = 1'b1;
      err_d[fin_ch]  = fin_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= '0;
      err_q  <= '0;
    end else begin
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;

endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter #(
  parameter int NCH = 16,
  parameter int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hw_req,
  input  logic [NCH-1:0] sw_start,
  input  logic           abort,
  input  logic           link_set,
  input  logic [CHW-1:0] link_ch,
  input  logic           take,
  input  logic [CHW-1:0] take_ch,
  output logic           grant_valid,
  output logic [CHW-1:0] grant_ch
);

  logic [NCH-1:0] pend_q, pend_d;

  for (genvar g = 0; g < NCH; g++) begin : g_pend
    logic taken, linked;
    assign taken     = take && (take_ch == CHW'(g));
    assign linked    = link_set && (link_ch == CHW'(g));
    assign pend_d[g] = abort ? 1'b0
                     : (pend_q[g] & ~taken) | hw_req[g] | sw_start[g] | linked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  // lowest number wins
  always_comb begin
    grant_ch = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend_q[i]) grant_ch = CHW'(i);
    end
  end

  assign grant_valid = (|pend_q) && !abort;

endmodule

// File: rtl/dma_core.sv
module dma_core
  import dma_pkg::*;
#(
  parameter int NCH = 16,
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int CW  = 16,
  parameter int CTW = 12,
  parameter int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           grant_valid,
  input  logic [CHW-1:0] grant_ch,
  output logic           take,
  output logic [CHW-1:0] rd_ch,
  input  logic [AW-1:0]  rd_cur_src,
  input  logic [AW-1:0]  rd_cur_dst,
  input  logic [AW-1:0]  rd_base_src,
  input  logic [AW-1:0]  rd_base_dst,
  input  logic [CW-1:0]  rd_rem,
  input  logic [CW-1:0]  rd_len,
  input  logic [CTW-1:0] rd_ctrl,
  input  logic           abort,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [1:0]     mem_size,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_ack,
  output logic           wb_en,
  output logic [CHW-1:0] wb_ch,
  output logic [AW-1:0]  wb_src,
  output logic [AW-1:0]  wb_dst,
  output logic [CW-1:0]  wb_rem,
  output logic           fin_en,
  output logic           fin_err,
  output logic [CHW-1:0] fin_ch,
  output logic           link_set,
  output logic [CHW-1:0] link_ch,
  output logic [NCH-1:0] irq,
  output logic           busy
);

  dma_state_e     state_q, state_d;
  logic [CHW-1:0] ch_q, ch_d;
  logic [AW-1:0]  src_q, src_d, dst_q, dst_d, step;
  logic [CW-1:0]  rem_q, rem_d, len_q, len_d;
  logic [CTW-1:0] ctrl_q, ctrl_d;
  logic [DW-1:0]  data_q, data_d;
  logic           abort_q, abort_d, err_q, err_d, abort_any, ld_en;
  logic [NCH-1:0] irq_q, irq_d;

  assign step      = AW'(step_of(ctrl_q[C_SIZE_LO +: 2]));
  assign abort_any = abort_q | abort;

  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    src_d   = src_q;
    dst_d   = dst_q;
    rem_d   = rem_q;
    len_d   = len_q;
    ctrl_d  = ctrl_q;
    data_d  = data_q;
    abort_d = abort_q;
    err_d   = err_q;
    irq_d   = '0;
    take    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (grant_valid) begin
          take    = 1'b1;
          ch_d    = grant_ch;
          src_d   = rd_cur_src;
          dst_d   = rd_cur_dst;
          rem_d   = rd_rem;
          len_d   = rd_len;
          ctrl_d  = rd_ctrl;
          abort_d = 1'b0;
          err_d   = 1'b0;
          state_d = ST_RD;
        end
      end
      ST_RD: begin
        if (abort) abort_d = 1'b1;
        if (mem_ack) begin
          data_d = mem_rdata;
          if (abort_any) begin
            err_d   = 1'b1;
            state_d = ST_FIN;
          end else begin
            state_d = ST_WR;
          end
        end
      end
      ST_WR: begin
        if (abort) abort_d = 1'b1;
        if (mem_ack) begin
          if (abort_any) begin
            err_d   = 1'b1;
            state_d = ST_FIN;
          end else begin
            src_d = ctrl_q[C_SRC_INC] ? src_q + step : src_q;
            dst_d = ctrl_q[C_DST_INC] ? dst_q + step : dst_q;
            rem_d = rem_q - CW'(1);
            if (rem_q <= CW'(1)) begin
              rem_d = len_q;
              if (ctrl_q[C_CIRC]) begin
                src_d = rd_base_src;
                dst_d = rd_base_dst;
              end
              state_d = ST_FIN;
            end else if (ctrl_q[C_SINGLE]) begin
              state_d = ST_FIN;
            end else begin
              state_d = ST_RD;
            end
          end
        end
      end
      default: begin
        if (!err_q && ctrl_q[C_INT]) irq_d[ch_q] = 1'b1;
        abort_d = 1'b0;
        state_d = ST_IDLE;
      end
    endcase
  end

  assign ld_en = take | mem_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      abort_q <= 1'b0;
      err_q   <= 1'b0;
      irq_q   <= '0;
    end else begin
      state_q <= state_d;
      abort_q <= abort_d;
      err_q   <= err_d;
      irq_q   <= irq_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_en) begin
      ch_q   <= ch_d;
      src_q  <= src_d;
      dst_q  <= dst_d;
      rem_q  <= rem_d;
      len_q  <= len_d;
      ctrl_q <= ctrl_d;
      data_q <= data_d;
    end
  end

  assign rd_ch     = (state_q == ST_IDLE) ? grant_ch : ch_q;
  assign mem_req   = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we    = (state_q == ST_WR);
  assign mem_addr  = (state_q == ST_WR) ? dst_q : src_q;
  assign mem_size  = ctrl_q[C_SIZE_LO +: 2];
  assign mem_wdata = data_q;
  assign fin_en    = (state_q == ST_FIN);
  assign fin_err   = err_q;
  assign fin_ch    = ch_q;
  assign wb_en     = fin_en && !err_q;
  assign wb_ch     = ch_q;
  assign wb_src    = src_q;
  assign wb_dst    = dst_q;
  assign wb_rem    = rem_q;
  assign link_set  = fin_en && !err_q && ctrl_q[C_LINK];
  assign link_ch   = ctrl_q[C_LCH_LO +: CHW];
  assign irq       = irq_q;
  assign busy      = (state_q != ST_IDLE);

endmodule

// File: rtl/dma_engine.sv
module dma_engine #(
  parameter  int NCH = 16,
  parameter  int AW  = 32,
  parameter  int DW  = 32,
  parameter  int CW  = 16,
  localparam int CHW = $clog2(NCH),
  localparam int CTW = 8 + CHW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [AW-1:0]  cfg_src,
  input  logic [AW-1:0]  cfg_dst,
  input  logic [CW-1:0]  cfg_len,
  input  logic [CTW-1:0] cfg_ctrl,
  input  logic [NCH-1:0] hw_req,
  input  logic [NCH-1:0] sw_start,
  input  logic           sw_abort,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [1:0]     mem_size,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_ack,
  output logic [NCH-1:0] irq,
  output logic [NCH-1:0] ch_done,
  output logic [NCH-1:0] ch_err,
  output logic           busy
);

  logic           grant_valid, take, wb_en, fin_en, fin_err, link_set;
  logic [CHW-1:0] grant_ch, rd_ch, wb_ch, fin_ch, link_ch;
  logic [AW-1:0]  rd_cur_src, rd_cur_dst, rd_base_src, rd_base_dst;
  logic [AW-1:0]  wb_src, wb_dst;
  logic [CW-1:0]  rd_rem, rd_len, wb_rem;
  logic [CTW-1:0] rd_ctrl;

  dma_desc_file #(.NCH(NCH), .AW(AW), .CW(CW), .CTW(CTW), .CHW(CHW)) u_desc (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .cfg_len(cfg_len), .cfg_ctrl(cfg_ctrl),
    .rd_ch(rd_ch), .rd_cur_src(rd_cur_src), .rd_cur_dst(rd_cur_dst),
    .rd_base_src(rd_base_src), .rd_base_dst(rd_base_dst),
    .rd_rem(rd_rem), .rd_len(rd_len), .rd_ctrl(rd_ctrl),
    .wb_en(wb_en), .wb_ch(wb_ch), .wb_src(wb_src), .wb_dst(wb_dst), .wb_rem(wb_rem),
    .clr_en(take), .clr_ch(grant_ch),
    .fin_en(fin_en), .fin_err(fin_err), .fin_ch(fin_ch),
    .done_o(ch_done), .err_o(ch_err)
  );

  dma_arbiter #(.NCH(NCH), .CHW(CHW)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .hw_req(hw_req), .sw_start(sw_start), .abort(sw_abort),
    .link_set(link_set), .link_ch(link_ch),
    .take(take), .take_ch(grant_ch),
    .grant_valid(grant_valid), .grant_ch(grant_ch)
  );

  dma_core #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW), .CTW(CTW), .CHW(CHW)) u_core (
    .clk(clk), .rst_n(rst_n),
    .grant_valid(grant_valid), .grant_ch(grant_ch),
    .take(take), .rd_ch(rd_ch),
    .rd_cur_src(rd_cur_src), .rd_cur_dst(rd_cur_dst),
    .rd_base_src(rd_base_src), .rd_base_dst(rd_base_dst),
    .rd_rem(rd_rem), .rd_len(rd_len), .rd_ctrl(rd_ctrl),
    .abort(sw_abort),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .wb_en(wb_en), .wb_ch(wb_ch), .wb_src(wb_src), .wb_dst(wb_dst), .wb_rem(wb_rem),
    .fin_en(fin_en), .fin_err(fin_err), .fin_ch(fin_ch),
    .link_set(link_set), .link_ch(link_ch),
    .irq(irq), .busy(busy)
  );

endmodule

// File: rtl/dma_engine_sva.sv
module dma_engine_sva #(
  parameter int NCH = 16,
  parameter int AW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sw_abort,
  input logic           mem_req,
  input logic           mem_we,
  input logic           mem_ack,
  input logic [AW-1:0]  mem_addr,
  input logic [NCH-1:0] irq,
  input logic [NCH-1:0] ch_done,
  input logic [NCH-1:0] ch_err,
  input logic           busy
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_write_after_read_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(mem_ack));

  p_irq_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq));

  p_irq_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq) |-> ((irq & ~ch_done) == '0));

  p_abort_no_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq) |-> ((irq & ch_err) == '0));

  p_abort_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_abort && mem_req && mem_ack) |=> !mem_req);

endmodule

bind dma_engine dma_engine_sva #(.NCH(NCH), .AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .sw_abort(sw_abort),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .irq(irq), .ch_done(ch_done), .ch_err(ch_err), .busy(busy)
);

// File: tb/sim_dma_engine.sv
`timescale 1ns/1ps
module sim_dma_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_ch = '0;
  logic [31:0] cfg_src = '0, cfg_dst = '0;
  logic [15:0] cfg_len = '0;
  logic [11:0] cfg_ctrl = '0;
  logic [15:0] hw_req = '0, sw_start = '0;
  logic        sw_abort = 1'b0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0]  mem_size;
  logic [31:0] mem_rdata;
  logic        mem_ack;
  logic [15:0] irq, ch_done, ch_err;
  logic        busy;

  int n_chk = 0;
  int n_fail = 0;

  logic        lg_we   [64];
  logic [31:0] lg_addr [64];
  logic [31:0] lg_data [64];
  logic [1:0]  lg_size [64];
  int          nlog;
  int          irq_cnt [16];

  always #2 clk = ~clk;

  dma_engine u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .cfg_len(cfg_len), .cfg_ctrl(cfg_ctrl),
    .hw_req(hw_req), .sw_start(sw_start), .sw_abort(sw_abort),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .irq(irq), .ch_done(ch_done), .ch_err(ch_err), .busy(busy)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  // memory responder: acknowledges one negedge after a request, logs every beat
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    nlog = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req && rst_n) begin
        mem_ack = 1'b1;
        if (!mem_we) mem_rdata = pat(mem_addr);
        if (nlog < 64) begin
          lg_we[nlog]   = mem_we;
          lg_addr[nlog] = mem_addr;
          lg_data[nlog] = mem_we ? mem_wdata : pat(mem_addr);
          lg_size[nlog] = mem_size;
        end
        nlog++;
      end
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) irq_cnt[i] = 0;
    forever begin
      @(negedge clk);
      for (int i = 0; i < 16; i++) if (irq[i]) irq_cnt[i]++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic prog(input logic [3:0] ch, input logic [31:0] s, input logic [31:0] d,
                      input logic [15:0] len, input logic [11:0] ctl);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_ch = ch; cfg_src = s; cfg_dst = d; cfg_len = len; cfg_ctrl = ctl;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic start_sw(input logic [15:0] m);
    @(posedge clk); #1; sw_start = m;
    @(posedge clk); #1; sw_start = '0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    int guard = 0;
    while (quiet < 4 && guard < 5000) begin
      @(posedge clk); #1;
      guard++;
      if (busy) quiet = 0; else quiet++;
    end
  endtask

  // {ch, src, dst, len, ctrl}; ctrl[1:0] size, [2] src inc, [3] dst inc, [6] irq enable
  localparam logic [95:0] VEC [4] = '{
    {4'd0,  32'h0000_1000, 32'h0000_2000, 16'd3, 12'h04C},
    {4'd4,  32'h0000_1100, 32'h0000_2100, 16'd2, 12'h009},
    {4'd11, 32'h0000_1200, 32'h0000_2200, 16'd4, 12'h006},
    {4'd15, 32'h0000_1300, 32'h0000_2300, 16'd1, 12'h00E}
  };

  logic [3:0]  tch;
  logic [31:0] tsrc, tdst, ra, wa, stp;
  logic [15:0] tlen;
  logic [11:0] tctl;
  int          base, icnt;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check("R1 mem_req", {31'd0, mem_req}, 32'd0);
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 irq", {16'd0, irq}, 32'd0);
    check("R1 done", {16'd0, ch_done}, 32'd0);
    check("R1 err", {16'd0, ch_err}, 32'd0);

    // R2 R3 R4 R9: table of block transfers
    for (int v = 0; v < 4; v++) begin
      tch = VEC[v][95:92]; tsrc = VEC[v][91:60]; tdst = VEC[v][59:28];
      tlen = VEC[v][27:12]; tctl = VEC[v][11:0];
      prog(tch, tsrc, tdst, tlen, tctl);
      base = nlog; icnt = irq_cnt[tch];
      start_sw(16'(1) << tch);
      wait_idle();
      stp = 32'(1) << tctl[1:0];
      check("R2 beat count", 32'(nlog - base), 32'(2 * tlen));
      for (int k = 0; k < int'(tlen); k++) begin
        ra = tsrc + (tctl[2] ? stp * 32'(k) : 32'd0);
        wa = tdst + (tctl[3] ? stp * 32'(k) : 32'd0);
        check("R4 read addr", lg_addr[base + 2*k], ra);
        check("R2 read first", {31'd0, lg_we[base + 2*k]}, 32'd0);
        check("R4 write addr", lg_addr[base + 2*k + 1], wa);
        check("R2 write data", lg_data[base + 2*k + 1], pat(ra));
        check("R3 size", {30'd0, lg_size[base + 2*k + 1]}, {30'd0, tctl[1:0]});
      end
      check("R9 done", {31'd0, ch_done[tch]}, 32'd1);
      check("R9 irq count", 32'(irq_cnt[tch] - icnt), tctl[6] ? 32'd1 : 32'd0);
    end

    // R5 single mode: ch10, 16-bit, both inc, single, irq
    prog(4'd10, 32'h4000, 32'h5000, 16'd3, 12'h05D);
    base = nlog; icnt = irq_cnt[10];
    start_sw(16'h0400); wait_idle();
    check("R5 one item", 32'(nlog - base), 32'd2);
    check("R5 irq per item", 32'(irq_cnt[10] - icnt), 32'd1);
    base = nlog;
    start_sw(16'h0400); wait_idle();
    check("R5 next read", lg_addr[base], 32'h4002);
    check("R5 next write", lg_addr[base + 1], 32'h5002);

    // R6 circular (ch7) against non-circular (ch8)
    prog(4'd7, 32'h6000, 32'h7000, 16'd2, 12'h02E);
    start_sw(16'h0080); wait_idle();
    base = nlog;
    start_sw(16'h0080); wait_idle();
    check("R6 circ src restart", lg_addr[base], 32'h6000);
    check("R6 circ dst restart", lg_addr[base + 3], 32'h7004);
    prog(4'd8, 32'h6100, 32'h7100, 16'd2, 12'h00E);
    start_sw(16'h0100); wait_idle();
    base = nlog;
    start_sw(16'h0100); wait_idle();
    check("R6 linear continue", lg_addr[base], 32'h6108);

    // R7 hardware request
    prog(4'd12, 32'h8000, 32'h8100, 16'd1, 12'h00E);
    base = nlog;
    @(posedge clk); #1 hw_req = 16'h1000;
    @(posedge clk); #1 hw_req = '0;
    wait_idle();
    check("R7 hw beats", 32'(nlog - base), 32'd2);
    check("R7 hw write", lg_addr[base + 1], 32'h8100);

    // R8 priority: ch5 and ch2 together
    prog(4'd2, 32'h3000, 32'h3800, 16'd2, 12'h00E);
    prog(4'd5, 32'h3100, 32'h3900, 16'd1, 12'h00E);
    base = nlog;
    start_sw(16'h0024); wait_idle();
    check("R8 lowest first", lg_addr[base], 32'h3000);
    check("R8 block kept", lg_addr[base + 2], 32'h3004);
    check("R8 then higher", lg_addr[base + 4], 32'h3100);

    // R10 link: ch1 -> ch9
    prog(4'd1, 32'h9000, 32'h9100, 16'd1, 12'h98E);
    prog(4'd9, 32'h9200, 32'h9300, 16'd1, 12'h04E);
    base = nlog; icnt = irq_cnt[9];
    start_sw(16'h0002); wait_idle();
    check("R10 beats", 32'(nlog - base), 32'd4);
    check("R10 target read", lg_addr[base + 2], 32'h9200);
    check("R10 target done", {31'd0, ch_done[9]}, 32'd1);
    check("R10 target irq", 32'(irq_cnt[9] - icnt), 32'd1);

    // R11 abort between read and write of first item; ch6 pending at the time
    prog(4'd3, 32'hA000, 32'hA800, 16'd8, 12'h04E);
    prog(4'd6, 32'hB000, 32'hB800, 16'd1, 12'h04E);
    base = nlog; icnt = irq_cnt[3];
    start_sw(16'h0008);
    start_sw(16'h0040);
    for (int g = 0; g < 200 && nlog < base + 1; g++) begin
      @(posedge clk); #1;
    end
    sw_abort = 1'b1;
    @(posedge clk); #1 sw_abort = 1'b0;
    wait_idle();
    repeat (20) @(posedge clk);
    #1;
    check("R11 beat in flight only", 32'(nlog - base), 32'd2);
    check("R11 write completed", {31'd0, lg_we[base + 1]}, 32'd1);
    check("R11 err flag", {31'd0, ch_err[3]}, 32'd1);
    check("R11 done flag", {31'd0, ch_done[3]}, 32'd1);
    check("R11 no irq", 32'(irq_cnt[3] - icnt), 32'd0);
    check("R11 pending dropped", {31'd0, ch_done[6]}, 32'd0);

    // R12 descriptor write clears flags
    prog(4'd3, 32'hA000, 32'hA800, 16'd1, 12'h00E);
    check("R12 err cleared", {31'd0, ch_err[3]}, 32'd0);
    check("R12 done cleared", {31'd0, ch_done[3]}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule